// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

This block is a watchdog peripheral with two clock domains. Software sits on a fast bus clock and writes a small register set. The timer runs on a slow functional clock. The timer is an up-counter. It restarts from a programmable load value, so the load value sets how many ticks remain before overflow. An optional prescaler divides the functional clock by a power of two. A write to the trigger register restarts the countdown. The timer can only be started or stopped by writing a matching pair of key words, in order, to the key register.

Every register write is posted from the bus domain to the functional domain through a toggle handshake. A pending-status register shows, one bit per register, which writes have not yet been applied and acknowledged. A write that arrives while its register's bit is set is dropped.

When a tick finds the counter at all-ones, the block drives a reset pulse of fixed length. It then reloads the counter and counts on.

The counter value is returned to the bus through a snapshot that is refreshed on every functional-clock cycle. The design assumes the bus clock is at least four times faster than the functional clock.

Top module: `wdt_keyseq_top`

## Requirements
- R1: After reset the timer is stopped, the counter is 0, `wdt_rst` is low, and the CTRL, LOAD, TRIG, KEY and PEND registers all read 0.
- R2: Offset 0x00 reads the parameter `REV_CODE` in bits 7:0, with zeros above.
- R3: PEND (offset 0x18) has bit 0 for CTRL (0x04), bit 2 for LOAD (0x0C), bit 3 for TRIG (0x10) and bit 4 for KEY (0x14). A bit is set from the bus edge that accepts a write until the functional domain has applied the write and acknowledged it. A write to a register whose bit is set is dropped, and the register keeps its previous value.
- R4: An accepted write takes effect in the functional domain at the third functional-clock rising edge after the bus edge that accepted it.
- R5: Key words are compared on bits 15:0 of the KEY register. The word 0xBBBB followed by 0x4444 starts the timer. The word 0xAAAA followed by 0x5555 stops it.
- R6: After a first key word, any word other than its matching second word returns the detector to idle and leaves the run state unchanged. While the detector is idle, any word other than a first key word is ignored.
- R7: Any write to TRIG reloads the counter from the load value held before that edge. A reset pulse in progress takes priority over a trigger.
- R8: While the timer is running, the counter adds one per tick. With CTRL bit 5 clear there is a tick on every functional-clock cycle. With bit 5 set there is a tick every 2^N cycles, where N is CTRL bits 4:2. While the timer is stopped, the counter holds its value.
- R9: When a tick finds the counter at all-ones, `wdt_rst` goes high for `RST_CYC` functional-clock cycles and the counter is frozen. On the edge where the pulse ends, the counter is loaded from LOAD.
- R10: CNT (offset 0x08) returns a snapshot of the counter. While the timer has been stopped for several functional cycles, the snapshot equals the counter exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus (interface) clock |
| fclk | input | 1 | Slow functional clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_wr | input | 1 | Write strobe, sampled on pclk |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| wdt_rst | output | 1 | Watchdog reset pulse (fclk domain) |

## Verification
A behavioural model in the bench receives each posted write after a three-edge delay. It is compared with `wdt_rst` on every functional-clock cycle, so a shift of one cycle in the posting latency, the prescaler period or the pulse length is caught. The counter is run both without the prescaler and with a divide-by-four prescaler, and both runs reach overflow. This separates an error in the tick generation from an error in the reload after overflow. Key traffic covers valid start and stop pairs, a stray second word while idle, a start pair broken by a foreign word, and a stop pair broken by a start word. These cases separate a detector that resets correctly from one that arms too freely. A back-to-back write to LOAD checks that a write arriving while the bit is pending is dropped.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // byte offsets of the registers
  localparam int unsigned OFF_REV  = 'h00;
  localparam int unsigned OFF_CTRL = 'h04;
  localparam int unsigned OFF_CNT  = 'h08;
  localparam int unsigned OFF_LOAD = 'h0C;
  localparam int unsigned OFF_TRIG = 'h10;
  localparam int unsigned OFF_KEY  = 'h14;
  localparam int unsigned OFF_PEND = 'h18;

  // key words
  localparam logic [15:0] KEY_RUN1  = 16'hBBBB;
  localparam logic [15:0] KEY_RUN2  = 16'h4444;
  localparam logic [15:0] KEY_HALT1 = 16'hAAAA;
  localparam logic [15:0] KEY_HALT2 = 16'h5555;

  localparam int unsigned PTV_W = 3;

  typedef enum logic [1:0] {
    KS_IDLE     = 2'd0,
    KS_ARM_RUN  = 2'd1,
    KS_ARM_HALT = 2'd2
  } key_state_e;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/wdt_post_chan.sv
// One posted register: shadow held in the bus domain, apply pulse in fclk.
module wdt_post_chan #(
  parameter int unsigned W = 16
) (
  input  logic         pclk,
  input  logic         prst_n,
  input  logic         fclk,
  input  logic         frst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] shadow_o,
  output logic         busy_o,
  output logic         apply_o
);
  logic         req_q, req_d;
  logic         ack_s1_q, ack_s2_q;
  logic [W-1:0] shadow_q, shadow_d;
  logic         rq_s1_q, rq_s2_q, seen_q;
  logic         accept;

  assign busy_o = req_q ^ ack_s2_q;
  assign accept = wr_i & ~busy_o;

  always_comb begin
    req_d    = req_q;
    shadow_d = shadow_q;
    if (accept) begin
      req_d    = ~req_q;
      shadow_d = wdata_i;
    end
  end

  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) begin
      req_q    <= 1'b0;
      shadow_q <= '0;
      ack_s1_q <= 1'b0;
      ack_s2_q <= 1'b0;
    end else begin
      req_q    <= req_d;
      shadow_q <= shadow_d;
      ack_s1_q <= seen_q;
      ack_s2_q <= ack_s1_q;
    end
  end

  always_ff @(posedge fclk or negedge frst_n) begin
    if (!frst_n) begin
      rq_s1_q <= 1'b0;
      rq_s2_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      rq_s1_q <= req_q;
      rq_s2_q <= rq_s1_q;
      seen_q  <= rq_s2_q;
    end
  end

  assign apply_o  = rq_s2_q ^ seen_q;
  assign shadow_o = shadow_q;

  // R3: a write that meets a pending bit leaves the register alone
  p_drop_busy_r3: assert property (@(posedge pclk) disable iff (!prst_n)
    wr_i && busy_o |=> $stable(shadow_q));
  // R3: an accepted write raises the pending bit
  p_set_pend_r3: assert property (@(posedge pclk) disable iff (!prst_n)
    wr_i && !busy_o |=> busy_o);
  // R4: each posted write is applied in exactly one fclk cycle
  p_apply_once_r4: assert property (@(posedge fclk) disable iff (!frst_n)
    apply_o |=> !apply_o);
endmodule

// File: rtl/wdt_fcore.sv
// Functional-domain core: key detector, prescaler, counter, reset pulse.
module wdt_fcore
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned RST_CYC = 4
) (
  input  logic             fclk,
  input  logic             frst_n,
  input  logic             ctrl_apply,
  input  logic [PTV_W:0]   ctrl_data,   // {prescale enable, ratio}
  input  logic             ldr_apply,
  input  logic [CNT_W-1:0] ldr_data,
  input  logic             trg_apply,
  input  logic             key_apply,
  input  logic [15:0]      key_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rst_o
);
  localparam int unsigned PRE_W = (1 << PTV_W) - 1;
  localparam int unsigned PW    = $clog2(RST_CYC + 1);

  key_state_e       ks_q, ks_d;
  logic             run_q, run_d;
  logic             pre_en_q, pre_en_d;
  logic [PTV_W-1:0] ptv_q, ptv_d;
  logic [CNT_W-1:0] ldr_q, ldr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PW-1:0]    pulse_q, pulse_d;
  logic [PRE_W:0]   pre_lim;
  logic             pulse_on, tick;

  assign pulse_on = (pulse_q != '0);
  assign pre_lim  = ((PRE_W+1)'(1) << ptv_q) - (PRE_W+1)'(1);
  assign tick     = run_q & ~pulse_on & (~pre_en_q | ({1'b0, pre_q} == pre_lim));

  // configuration and key detector
  always_comb begin
    ks_d     = ks_q;
    run_d    = run_q;
    pre_en_d = pre_en_q;
    ptv_d    = ptv_q;
    ldr_d    = ldr_q;
    if (ctrl_apply) begin
      pre_en_d = ctrl_data[PTV_W];
      ptv_d    = ctrl_data[PTV_W-1:0];
    end
    if (ldr_apply) ldr_d = ldr_data;
    if (key_apply) begin
      unique case (ks_q)
        KS_IDLE: begin
          if (key_data == KEY_RUN1)       ks_d = KS_ARM_RUN;
          else if (key_data == KEY_HALT1) ks_d = KS_ARM_HALT;
        end
        KS_ARM_RUN: begin
          ks_d = KS_IDLE;
          if (key_data == KEY_RUN2) run_d = 1'b1;
        end
        KS_ARM_HALT: begin
          ks_d = KS_IDLE;
          if (key_data == KEY_HALT2) run_d = 1'b0;
        end
        default: ks_d = KS_IDLE;
      endcase
    end
  end

  // prescaler, counter and reset pulse
  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = pulse_q;
    pre_d   = (!run_q || pulse_on || tick) ? '0 : pre_q + PRE_W'(1);
    if (pulse_on) begin
      pulse_d = pulse_q - PW'(1);
      if (pulse_q == PW'(1)) cnt_d = ldr_q;
    end else if (trg_apply) begin
      cnt_d = ldr_q;
    end else if (tick) begin
      if (&cnt_q) pulse_d = PW'(RST_CYC);
      else        cnt_d   = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge fclk or negedge frst_n) begin
    if (!frst_n) begin
      ks_q     <= KS_IDLE;
      run_q    <= 1'b0;
      pre_en_q <= 1'b0;
      ptv_q    <= '0;
      ldr_q    <= '0;
      cnt_q    <= '0;
      pre_q    <= '0;
      pulse_q  <= '0;
    end else begin
      ks_q     <= ks_d;
      run_q    <= run_d;
      pre_en_q <= pre_en_d;
      ptv_q    <= ptv_d;
      ldr_q    <= ldr_d;
      cnt_q    <= cnt_d;
      pre_q    <= pre_d;
      pulse_q  <= pulse_d;
    end
  end

  assign cnt_o = cnt_q;
  assign rst_o = pulse_on;

  // R5: a completed start pair leaves the timer running
  p_key_start_r5: assert property (@(posedge fclk) disable iff (!frst_n)
    key_apply && ks_q == KS_ARM_RUN && key_data == KEY_RUN2 |=> run_q);
  // R6: a foreign word after a first word disarms and keeps the run state
  p_key_bad_r6: assert property (@(posedge fclk) disable iff (!frst_n)
    key_apply && ((ks_q == KS_ARM_RUN && key_data != KEY_RUN2) ||
                  (ks_q == KS_ARM_HALT && key_data != KEY_HALT2))
    |=> ks_q == KS_IDLE && $stable(run_q));
  // R8: a stopped timer without trigger or pulse holds its count
  p_hold_stop_r8: assert property (@(posedge fclk) disable iff (!frst_n)
    !run_q && !pulse_on && !trg_apply |=> $stable(cnt_q));
  // R9: the counter is frozen while the pulse continues
  p_pulse_freeze_r9: assert property (@(posedge fclk) disable iff (!frst_n)
    pulse_on && pulse_q != PW'(1) |=> $stable(cnt_q) && rst_o);
  // R9: at the end of the pulse the counter holds the load value
  p_reload_r9: assert property (@(posedge fclk) disable iff (!frst_n)
    $fell(rst_o) |-> cnt_q == $past(ldr_q));
endmodule

// File: rtl/wdt_keyseq_top.sv
module wdt_keyseq_top
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned RST_CYC  = 4,
  parameter logic [7:0]  REV_CODE = 8'h31
) (
  input  logic              pclk,
  input  logic              fclk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst
);
  logic prst_n, frst_n;
  wdt_rst_sync u_psync (.clk(pclk), .arst_n(rst_n), .srst_n(prst_n));
  wdt_rst_sync u_fsync (.clk(fclk), .arst_n(rst_n), .srst_n(frst_n));

  logic wr_ctrl, wr_load, wr_trig, wr_key;
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_load = bus_wr && (bus_addr == ADDR_W'(OFF_LOAD));
  assign wr_trig = bus_wr && (bus_addr == ADDR_W'(OFF_TRIG));
  assign wr_key  = bus_wr && (bus_addr == ADDR_W'(OFF_KEY));

  logic [PTV_W:0]    ctrl_sh;
  logic [CNT_W-1:0]  load_sh;
  logic [DATA_W-1:0] trig_sh;
  logic [15:0]       key_sh;
  logic b_ctrl, b_load, b_trig, b_key;
  logic a_ctrl, a_load, a_trig, a_key;

  wdt_post_chan #(.W(PTV_W+1)) u_ch_ctrl (
    .pclk(pclk), .prst_n(prst_n), .fclk(fclk), .frst_n(frst_n),
    .wr_i(wr_ctrl), .wdata_i(bus_wdata[PTV_W+2:2]),
    .shadow_o(ctrl_sh), .busy_o(b_ctrl), .apply_o(a_ctrl));
  wdt_post_chan #(.W(CNT_W)) u_ch_load (
    .pclk(pclk), .prst_n(prst_n), .fclk(fclk), .frst_n(frst_n),
    .wr_i(wr_load), .wdata_i(bus_wdata[CNT_W-1:0]),
    .shadow_o(load_sh), .busy_o(b_load), .apply_o(a_load));
  wdt_post_chan #(.W(DATA_W)) u_ch_trig (
    .pclk(pclk), .prst_n(prst_n), .fclk(fclk), .frst_n(frst_n),
    .wr_i(wr_trig), .wdata_i(bus_wdata),
    .shadow_o(trig_sh), .busy_o(b_trig), .apply_o(a_trig));
  wdt_post_chan #(.W(16)) u_ch_key (
    .pclk(pclk), .prst_n(prst_n), .fclk(fclk), .frst_n(frst_n),
    .wr_i(wr_key), .wdata_i(bus_wdata[15:0]),
    .shadow_o(key_sh), .busy_o(b_key), .apply_o(a_key));

  logic [CNT_W-1:0] cnt_f;
  wdt_fcore #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_core (
    .fclk(fclk), .frst_n(frst_n),
    .ctrl_apply(a_ctrl), .ctrl_data(ctrl_sh),
    .ldr_apply(a_load), .ldr_data(load_sh),
    .trg_apply(a_trig),
    .key_apply(a_key), .key_data(key_sh),
    .cnt_o(cnt_f), .rst_o(wdt_rst));

  // counter snapshot: copied each fclk edge, taken into pclk on toggle change
  logic [CNT_W-1:0] snap_q, cnt_rd_q, cnt_rd_d;
  logic             stg_q, st1_q, st2_q, st3_q;

  always_ff @(posedge fclk or negedge frst_n) begin
    if (!frst_n) begin
      snap_q <= '0;
      stg_q  <= 1'b0;
    end else begin
      snap_q <= cnt_f;
      stg_q  <= ~stg_q;
    end
  end

  assign cnt_rd_d = (st2_q ^ st3_q) ? snap_q : cnt_rd_q;

  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) begin
      st1_q    <= 1'b0;
      st2_q    <= 1'b0;
      st3_q    <= 1'b0;
      cnt_rd_q <= '0;
    end else begin
      st1_q    <= stg_q;
      st2_q    <= st1_q;
      st3_q    <= st2_q;
      cnt_rd_q <= cnt_rd_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(OFF_REV):  bus_rdata = DATA_W'(REV_CODE);
      ADDR_W'(OFF_CTRL): bus_rdata = DATA_W'({ctrl_sh, 2'b00});
      ADDR_W'(OFF_CNT):  bus_rdata = DATA_W'(cnt_rd_q);
      ADDR_W'(OFF_LOAD): bus_rdata = DATA_W'(load_sh);
      ADDR_W'(OFF_TRIG): bus_rdata = trig_sh;
      ADDR_W'(OFF_KEY):  bus_rdata = DATA_W'(key_sh);
      ADDR_W'(OFF_PEND): bus_rdata = DATA_W'({b_key, b_trig, b_load, 1'b0, b_ctrl});
      default:           bus_rdata = '0;
    endcase
  end

  // R10: the snapshot only moves when a fresh copy arrives
  p_snap_stable_r10: assert property (@(posedge pclk) disable iff (!prst_n)
    !(st2_q ^ st3_q) |=> $stable(cnt_rd_q));
endmodule

// File: tb/wdt_keyseq_top_tb.sv
module wdt_keyseq_top_tb_top;
  localparam int PCLK_P  = 10;
  localparam int FCLK_P  = 80;
  localparam int RST_CYC = 4;

  logic        pclk = 1'b0, fclk = 1'b0, rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst;

  always #(PCLK_P/2) pclk = ~pclk;
  always #(FCLK_P/2) fclk = ~fclk;

  wdt_keyseq_top #(.RST_CYC(RST_CYC), .REV_CODE(8'h31)) dut_i (
    .pclk(pclk), .fclk(fclk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst(wdt_rst));

  int n_chk = 0, n_fail = 0, pulse_seen = 0, pulse_len = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model (fclk domain) -----------
  typedef struct { int ch; logic [31:0] d; int cnt; } pw_t;
  pw_t mq[$];
  bit          m_run, m_pre_en, m_on;
  int          m_ks, m_ptv, m_pre, m_pulse;
  logic [31:0] m_ldr, m_cnt;

  always @(posedge fclk) begin
    automatic bit tick, trg;
    automatic logic [31:0] ncnt;
    automatic int npulse, npre;
    automatic pw_t keep[$];
    if (!rst_n) begin
      m_run = 0; m_pre_en = 0; m_ks = 0; m_ptv = 0; m_pre = 0;
      m_pulse = 0; m_ldr = 0; m_cnt = 0; mq = {};
    end else begin
      tick = m_run && m_pulse == 0 && (!m_pre_en || m_pre == (1 << m_ptv) - 1);
      trg = 0;
      foreach (mq[i]) if (mq[i].ch == 3 && mq[i].cnt == 1) trg = 1;
      ncnt = m_cnt; npulse = m_pulse;
      npre = (!m_run || m_pulse != 0 || tick) ? 0 : m_pre + 1;
      if (m_pulse != 0) begin
        npulse = m_pulse - 1;
        if (m_pulse == 1) ncnt = m_ldr;
      end else if (trg) ncnt = m_ldr;
      else if (tick) begin
        if (m_cnt == 32'hFFFF_FFFF) npulse = RST_CYC; else ncnt = m_cnt + 1;
      end
      for (int i = 0; i < mq.size(); i++) begin
        automatic pw_t e = mq[i];
        e.cnt--;
        if (e.cnt > 0) keep.push_back(e);
        else if (e.ch == 0) begin m_pre_en = e.d[5]; m_ptv = int'(e.d[4:2]); end
        else if (e.ch == 2) m_ldr = e.d;
        else if (e.ch == 4) begin
          if (m_ks == 0) m_ks = (e.d[15:0] == 16'hBBBB) ? 1 : (e.d[15:0] == 16'hAAAA) ? 2 : 0;
          else begin
            if (m_ks == 1 && e.d[15:0] == 16'h4444) m_run = 1;
            if (m_ks == 2 && e.d[15:0] == 16'h5555) m_run = 0;
            m_ks = 0;
          end
        end
      end
      mq = keep;
      m_cnt = ncnt; m_pulse = npulse; m_pre = npre;
    end
  end

  // R4 R9: reset output against the model on every functional cycle
  always @(negedge fclk) begin
    if (m_on) begin
      chk("R4/R9 wdt_rst vs model", 32'(wdt_rst), 32'(m_pulse != 0));
      if (wdt_rst) pulse_len++;
      else if (pulse_len != 0) begin
        pulse_seen++;
        chk("R9 pulse length", pulse_len, RST_CYC);
        pulse_len = 0;
      end
    end
  end

  // ---------------- bus tasks ------------------------------------------
  task automatic bus_write(int addr, logic [31:0] d, bit accepted);
    int ch;
    @(negedge pclk);
    bus_wr = 1; bus_addr = 5'(addr); bus_wdata = d;
    @(posedge pclk);
    #1;
    bus_wr = 0;
    ch = (addr == 'h04) ? 0 : (addr == 'h0C) ? 2 : (addr == 'h10) ? 3 : 4;
    if (accepted) mq.push_back('{ch, d, 3});
  endtask

  task automatic bus_read(int addr, output logic [31:0] d);
    @(negedge pclk);
    bus_addr = 5'(addr);
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] p;
    for (int i = 0; i < 2000; i++) begin
      bus_read('h18, p);
      if (p == 0) return;
    end
    chk("R3 pending never cleared", p, 0);
  endtask

  task automatic wr(int addr, logic [31:0] d);
    bus_write(addr, d, 1);
    wait_idle();
  endtask

  task automatic fwait(int n);
    repeat (n) @(posedge fclk);
  endtask

  task automatic read_cnt_model(string req);
    logic [31:0] v;
    fwait(4);
    bus_read('h08, v);
    chk(req, v, m_cnt);
  endtask

  // ---------------- stimulus -------------------------------------------
  initial begin
    logic [31:0] v, c1, c2;
    rst_n = 0;
    fwait(3);
    rst_n = 1;
    fwait(4);
    m_on = 1;

    // R1 reset state, R2 revision
    bus_read('h00, v); chk("R2 revision", v, 32'h31);
    bus_read('h04, v); chk("R1 ctrl", v, 0);
    bus_read('h0C, v); chk("R1 load", v, 0);
    bus_read('h18, v); chk("R1 pending", v, 0);
    bus_read('h08, v); chk("R1 counter", v, 0);
    chk("R1 wdt_rst", 32'(wdt_rst), 0);

    // R3 pending bit and dropped write
    bus_write('h0C, 32'hFFFF_FFF0, 1);
    bus_read('h18, v); chk("R3 load pending bit 2", v, 32'h4);
    bus_write('h0C, 32'h1234_5678, 0);
    wait_idle();
    bus_read('h0C, v); chk("R3 dropped write keeps load", v, 32'hFFFF_FFF0);
    bus_write('h14, 32'h0, 1);
    bus_read('h18, v); chk("R3 key pending bit 4", v, 32'h10);
    wait_idle();

    // R7 trigger reload while stopped
    bus_write('h10, 32'h1234, 1);
    bus_read('h18, v); chk("R3 trig pending bit 3", v, 32'h8);
    wait_idle();
    read_cnt_model("R7 reload on trigger");
    chk("R7 reload value", m_cnt, 32'hFFFF_FFF0);

    // R6 stray second word while idle
    wr('h14, 32'h4444);
    read_cnt_model("R6 stray word keeps stopped");
    bus_read('h08, c1); fwait(6); bus_read('h08, c2);
    chk("R6 counter holds", c2, c1);

    // R6 broken start pair
    wr('h14, 32'hBBBB); wr('h14, 32'h1234); wr('h14, 32'h4444);
    fwait(6); bus_read('h08, c2);
    chk("R6 broken start pair", c2, c1);

    // R5 start, R8 full-rate count, R9 overflow
    wr('h14, 32'hBBBB); wr('h14, 32'h4444);
    fwait(40);
    chk("R9 pulse seen (no prescaler)", 32'(pulse_seen > 0), 1);
    // R6 broken stop pair keeps running
    wr('h14, 32'hAAAA); wr('h14, 32'h4444);
    bus_read('h08, c1); fwait(6); bus_read('h08, c2);
    chk("R6 broken stop pair still running", 32'(c2 != c1), 1);
    // R5 stop
    wr('h14, 32'hAAAA); wr('h14, 32'h5555);
    read_cnt_model("R5 stopped count (R10 snapshot)");
    bus_read('h08, c1); fwait(6); bus_read('h08, c2);
    chk("R8 counter holds when stopped", c2, c1);

    // R8 prescaler divide by 4
    pulse_seen = 0;
    wr('h04, 32'h28);
    bus_read('h04, v); chk("R8 ctrl readback", v, 32'h28);
    wr('h0C, 32'hFFFF_FFF8);
    wr('h10, 32'h1);
    read_cnt_model("R7 reload with new load");
    wr('h14, 32'hBBBB); wr('h14, 32'h4444);
    fwait(20);
    wr('h14, 32'hAAAA); wr('h14, 32'h5555);
    read_cnt_model("R8 prescaled count");
    wr('h14, 32'hBBBB); wr('h14, 32'h4444);
    fwait(60);
    chk("R9 pulse seen (prescaler)", 32'(pulse_seen > 0), 1);
    wr('h14, 32'hAAAA); wr('h14, 32'h5555);
    read_cnt_model("R10 snapshot after prescaled run");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(PCLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule